// File: doc/BRIEF.md
# Alignment Marker Lock with Rapid Markers

This block tracks the alignment marker position on one lane of a multi-lane 64b/66b receive path. It watches a stream of decoded blocks. Each block arrives with a valid strobe, a flag that says whether the block is a valid marker, and the lane number carried by that marker. From this it decides whether the marker repeats at the expected spacing and carries the same lane identity.

When low-power idle is in effect, the transmitter sends markers at a much shorter spacing. The block reads the receive-side low-power flag and switches the expected spacing at once. Lock and the established marker position survive a change from normal to rapid markers and a change back. Only lane numbers are compared, so a rapid marker and a normal marker from the same lane count as the same marker.

When four marker slots in a row fail the comparison, the block asks the external datapath to slip. It holds that request until the datapath confirms the slip, and then searches for a marker again.

Top module: `marker_lock_top`

## Requirements
- R1: A synchronous active-high reset clears `am_lock`, `slip_req` and `lock_lane` to 0 and puts the block into marker search.
- R2: In search, the first valid block with `mk_found`=1 stores `mk_lane` on `lock_lane`. `am_lock` goes to 1 only when the valid block in the next marker slot carries a marker with the same lane number.
- R3: During acquisition, a next-slot block without a marker, or with a different lane number, raises `slip_req`. Lock is not asserted.
- R4: With `rx_lpi_active`=0, a marker slot is the valid block that follows `NORMAL_TC` (default 16383) non-slot valid blocks after the previous slot. No earlier block is judged.
- R5: With `rx_lpi_active`=1, the spacing is 7 non-slot blocks when `RAPID_100G`=1 and 15 when it is 0.
- R6: While locked and counting a normal period, a valid block with `rx_lpi_active`=1 restarts the interval count. If that block carries a marker, it becomes the new reference (count 0). Otherwise it counts as the first block of the new interval. In both cases lock is kept.
- R7: The spacing in use follows `rx_lpi_active` on every block. A fall of the flag in the middle of a rapid period extends that same period to the normal spacing. A slot is taken when the count reaches or passes the spacing in use.
- R8: A matching marker in a slot resets the consecutive-miss count to 0. After a match, three further misses do not drop lock.
- R9: A slot without a matching marker counts as a miss. On the fourth consecutive miss, `am_lock` falls and `slip_req` rises on the same clock edge. Fewer misses leave `am_lock` at 1.
- R10: `slip_req` stays at 1 until `slip_done` is seen, ignoring all blocks meanwhile. On the edge after `slip_done`, the block returns to search with `slip_req`=0 and `am_lock`=0.
- R11: Cycles with `blk_valid`=0 change nothing: markers are ignored and the interval count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid | input | 1 | A 66-bit block is present this cycle |
| mk_found | input | 1 | The present block is a valid normal or rapid marker |
| mk_lane | input | LANE_W | Lane number decoded from the marker |
| rx_lpi_active | input | 1 | Receive low-power idle in effect (rapid marker spacing) |
| slip_done | input | 1 | The datapath has completed the requested slip |
| am_lock | output | 1 | Marker lock established |
| slip_req | output | 1 | Request to slip the block boundary |
| lock_lane | output | LANE_W | Lane number captured at acquisition |

## Verification
The bench targets the switch between spacings. It raises the low-power flag on a marker partway through a normal period; a design that failed to restart would judge the wrong block and collect misses. It also drops the flag right after a rapid marker; a design that kept the short spacing would add a miss, and the three misses that follow would then cause a slip. One stimulus of rapid markers alternates lane numbers so that the 100G and 40G variants see different slot contents. An exchanged rapid spacing therefore shows up as a slip on the wrong instance. Further cases are a match after three misses, a wrong second marker during acquisition, and markers arriving while a slip is pending. A bad miss counter or a lost slip hold would change lock or slip timing.

// File: rtl/am_rlock_pkg.sv
package am_rlock_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_VERIFY,
        ST_TRACK,
        ST_RAPID,
        ST_SLIP
    } lock_st_e;

    typedef struct packed {
        logic clr;
        logic load_one;
        logic inc;
    } span_cmd_t;

    localparam int unsigned MISS_LIMIT = 4;

    function automatic int unsigned rapid_span(input bit is_100g);
        return is_100g ? 7 : 15;
    endfunction

endpackage

// File: rtl/mk_span_ctr.sv
module mk_span_ctr
    import am_rlock_pkg::*;
#(
    parameter int unsigned NORMAL_TC = 16383,
    parameter int unsigned RAPID_TC  = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  span_cmd_t cmd,
    input  logic      lpi,
    output logic      at_slot
);
    localparam int unsigned CW = $clog2(NORMAL_TC + 1);
    localparam logic [CW-1:0] NORM_V  = CW'(NORMAL_TC);
    localparam logic [CW-1:0] RAPID_V = CW'(RAPID_TC);

    logic [CW-1:0] cnt;
    logic [CW-1:0] tc_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cmd.clr) begin
            cnt <= {{(CW-1){1'b0}}, cmd.load_one};
        end else if (cmd.inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        tc_now  = lpi ? RAPID_V : NORM_V;
        at_slot = (cnt >= tc_now);
    end

    // R4: the interval count never runs past the normal spacing
    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= NORM_V);

    // R11: an idle command leaves the count alone
    a_r11_cnt_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmd.clr && !cmd.inc) |=> $stable(cnt));

endmodule

// File: rtl/mk_miss_tally.sv
module mk_miss_tally
    import am_rlock_pkg::*;
#(
    parameter int unsigned LIMIT = MISS_LIMIT
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int unsigned TW = $clog2(LIMIT + 1);

    logic [TW-1:0] tally;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tally <= '0;
        end else if (bump) begin
            tally <= tally + 1'b1;
        end
    end

    assign last = (tally == TW'(LIMIT - 1));

    // R9: the tally is cleared before it can reach the slip limit
    a_r9_tally_below_limit: assert property (@(posedge clk) disable iff (rst)
        tally < TW'(LIMIT));

    // R8: a clear request empties the tally
    a_r8_tally_cleared: assert property (@(posedge clk) disable iff (rst)
        clr |=> (tally == '0));

endmodule

// File: rtl/marker_lock_top.sv
module marker_lock_top
    import am_rlock_pkg::*;
#(
    parameter int unsigned LANE_W     = 5,
    parameter int unsigned NORMAL_TC  = 16383,
    parameter bit          RAPID_100G = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              blk_valid,
    input  logic              mk_found,
    input  logic [LANE_W-1:0] mk_lane,
    input  logic              rx_lpi_active,
    input  logic              slip_done,
    output logic              am_lock,
    output logic              slip_req,
    output logic [LANE_W-1:0] lock_lane
);
    localparam int unsigned RAPID_TC = rapid_span(RAPID_100G);

    lock_st_e          st, st_nx;
    span_cmd_t         cmd;
    logic              at_slot;
    logic              t_clr, t_bump, t_last;
    logic              set_lock, drop_lock, cap;
    logic              lane_ok;
    logic [LANE_W-1:0] lane_q;

    mk_span_ctr #(
        .NORMAL_TC (NORMAL_TC),
        .RAPID_TC  (RAPID_TC)
    ) i_span (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .lpi     (rx_lpi_active),
        .at_slot (at_slot)
    );

    mk_miss_tally #(
        .LIMIT (MISS_LIMIT)
    ) i_tally (
        .clk  (clk),
        .rst  (rst),
        .clr  (t_clr),
        .bump (t_bump),
        .last (t_last)
    );

    assign lane_ok = mk_found && (mk_lane == lane_q);

    always_comb begin
        st_nx     = st;
        cmd       = '0;
        t_clr     = 1'b0;
        t_bump    = 1'b0;
        set_lock  = 1'b0;
        drop_lock = 1'b0;
        cap       = 1'b0;
        unique case (st)
            ST_HUNT: begin
                if (blk_valid && mk_found) begin
                    cap     = 1'b1;
                    cmd.clr = 1'b1;
                    st_nx   = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (blk_valid) begin
                    if (at_slot) begin
                        if (lane_ok) begin
                            set_lock = 1'b1;
                            t_clr    = 1'b1;
                            cmd.clr  = 1'b1;
                            st_nx    = ST_TRACK;
                        end else begin
                            st_nx = ST_SLIP;
                        end
                    end else begin
                        cmd.inc = 1'b1;
                    end
                end
            end
            ST_TRACK, ST_RAPID: begin
                if (blk_valid) begin
                    if (st == ST_TRACK && rx_lpi_active) begin
                        cmd.clr      = 1'b1;
                        cmd.load_one = !mk_found;
                        st_nx        = ST_RAPID;
                    end else if (at_slot) begin
                        if (lane_ok) begin
                            t_clr   = 1'b1;
                            cmd.clr = 1'b1;
                            st_nx   = ST_TRACK;
                        end else if (t_last) begin
                            drop_lock = 1'b1;
                            t_clr     = 1'b1;
                            st_nx     = ST_SLIP;
                        end else begin
                            t_bump  = 1'b1;
                            cmd.clr = 1'b1;
                            st_nx   = ST_TRACK;
                        end
                    end else begin
                        cmd.inc = 1'b1;
                    end
                end
            end
            ST_SLIP: begin
                if (slip_done) begin
                    cmd.clr = 1'b1;
                    t_clr   = 1'b1;
                    st_nx   = ST_HUNT;
                end
            end
            default: st_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HUNT;
            am_lock <= 1'b0;
            lane_q  <= '0;
        end else begin
            st <= st_nx;
            if (set_lock) begin
                am_lock <= 1'b1;
            end else if (drop_lock) begin
                am_lock <= 1'b0;
            end
            if (cap) begin
                lane_q <= mk_lane;
            end
        end
    end

    assign slip_req  = (st == ST_SLIP);
    assign lock_lane = lane_q;

    // R1: reset leaves the block unlocked and not slipping
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!am_lock && !slip_req && lock_lane == '0));

    // R2: lock only rises on a valid marker that matches the captured lane
    a_r2_lock_on_match: assert property (@(posedge clk) disable iff (rst)
        $rose(am_lock) |-> $past(blk_valid && mk_found && mk_lane == lane_q));

    // R9: lock never coexists with a pending slip
    a_r9_slip_unlocked: assert property (@(posedge clk) disable iff (rst)
        slip_req |-> !am_lock);

    // R9: lock falls only into a slip
    a_r9_drop_to_slip: assert property (@(posedge clk) disable iff (rst)
        $fell(am_lock) |-> slip_req);

    // R10: slip request is held until the handshake
    a_r10_slip_held: assert property (@(posedge clk) disable iff (rst)
        (slip_req && !slip_done) |=> slip_req);

    // R10: the handshake ends the slip and returns to search unlocked
    a_r10_slip_exit: assert property (@(posedge clk) disable iff (rst)
        (slip_req && slip_done) |=> (!slip_req && !am_lock));

    // R11: an empty cycle outside a slip changes neither lock nor lane
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!blk_valid && !slip_req) |=> ($stable(am_lock) && $stable(lock_lane)));

endmodule

// File: tb/test_marker_lock_top.sv
module marker_ref #(
    parameter int NTC = 20,
    parameter int RTC = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       v,
    input  logic       d,
    input  logic [4:0] l,
    input  logic       p,
    input  logic       sd,
    output logic       m_lock,
    output logic       m_slip,
    output logic [4:0] m_lane
);
    // mode: 0 search, 1 acquire, 2 normal locked, 3 after lpi restart, 4 slipping
    int mode;
    int since;
    int misses;

    always @(posedge clk) begin
        int span;
        if (rst) begin
            mode = 0; since = 0; misses = 0;
            m_lock <= 1'b0; m_lane <= '0;
        end else if (mode == 4) begin
            if (sd) begin
                mode = 0; since = 0; misses = 0;
            end
        end else if (v) begin
            span = p ? RTC : NTC;
            if (mode == 0) begin
                if (d) begin
                    m_lane <= l; since = 0; mode = 1;
                end
            end else if (mode == 1) begin
                if (since >= span) begin
                    if (d && l == m_lane) begin
                        m_lock <= 1'b1; mode = 2; since = 0; misses = 0;
                    end else begin
                        mode = 4;
                    end
                end else since++;
            end else if (mode == 2 && p) begin
                mode = 3; since = d ? 0 : 1;
            end else if (since >= span) begin
                if (d && l == m_lane) begin
                    misses = 0; since = 0; mode = 2;
                end else if (misses == 3) begin
                    misses = 0; mode = 4; m_lock <= 1'b0;
                end else begin
                    misses++; since = 0; mode = 2;
                end
            end else since++;
        end
    end

    assign m_slip = (mode == 4) && !rst;
endmodule

module test_marker_lock_top;
    localparam int NTC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       v = 1'b0, d = 1'b0, p = 1'b0, sd = 1'b0;
    logic [4:0] l = '0;

    logic       lock_a, slip_a, lock_b, slip_b;
    logic [4:0] lane_a, lane_b;
    logic       ml_a, ms_a, ml_b, ms_b;
    logic [4:0] mn_a, mn_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    marker_lock_top #(.LANE_W(5), .NORMAL_TC(NTC), .RAPID_100G(1'b1)) i_marker_lock_top (
        .clk(clk), .rst(rst), .blk_valid(v), .mk_found(d), .mk_lane(l),
        .rx_lpi_active(p), .slip_done(sd),
        .am_lock(lock_a), .slip_req(slip_a), .lock_lane(lane_a));

    marker_lock_top #(.LANE_W(5), .NORMAL_TC(NTC), .RAPID_100G(1'b0)) i_marker_lock_top_40g (
        .clk(clk), .rst(rst), .blk_valid(v), .mk_found(d), .mk_lane(l),
        .rx_lpi_active(p), .slip_done(sd),
        .am_lock(lock_b), .slip_req(slip_b), .lock_lane(lane_b));

    marker_ref #(.NTC(NTC), .RTC(7)) i_ref_a (
        .clk(clk), .rst(rst), .v(v), .d(d), .l(l), .p(p), .sd(sd),
        .m_lock(ml_a), .m_slip(ms_a), .m_lane(mn_a));

    marker_ref #(.NTC(NTC), .RTC(15)) i_ref_b (
        .clk(clk), .rst(rst), .v(v), .d(d), .l(l), .p(p), .sd(sd),
        .m_lock(ml_b), .m_slip(ms_b), .m_lane(mn_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // per-clock comparison against the behavioural models
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk({phase, " model lock 100G"}, lock_a, ml_a);
            chk({phase, " model slip 100G"}, slip_a, ms_a);
            chk({phase, " model lane 100G"}, lane_a, mn_a);
            chk({phase, " model lock 40G"},  lock_b, ml_b);
            chk({phase, " model slip 40G"},  slip_b, ms_b);
            chk({phase, " model lane 40G"},  lane_b, mn_b);
        end
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(input logic vv, input logic dd, input logic [4:0] ll, input logic pp);
        v = vv; d = dd; l = ll; p = pp;
        @(negedge clk);
        v = 1'b0; d = 1'b0;
    endtask

    task automatic data(input int n, input logic pp);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 5'd0, pp);
    endtask

    task automatic done_pulse();
        sd = 1'b1;
        @(negedge clk);
        sd = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic acquire5();
        step(1'b1, 1'b1, 5'd5, 1'b0);
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        phase = "R1";
        chk("R1 lock after reset", lock_a, 0);
        chk("R1 slip after reset", slip_a, 0);
        chk("R1 lane after reset", lane_a, 0);

        phase = "R11";
        repeat (3) step(1'b0, 1'b1, 5'd5, 1'b0);
        chk("R11 invalid marker not captured", lane_a, 0);

        phase = "R2";
        step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R2 lane captured", lane_a, 5);
        chk("R2 no lock on first marker", lock_a, 0);
        for (int i = 0; i < NTC; i++) begin
            step(1'b1, 1'b0, 5'd0, 1'b0);
            if (i % 5 == 0) step(1'b0, 1'b1, 5'd3, 1'b0); // R11 gaps
        end
        chk("R4 no lock before slot", lock_a, 0);
        chk("R11 gaps ignored for lane", lane_a, 5);
        step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R2 lock at second marker", lock_a, 1);
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R4 lock held over normal period", lock_a, 1);

        phase = "R6";
        data(6, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b1);
        chk("R6 lock kept on lpi rise", lock_a, 1);
        for (int k = 0; k < 3; k++) begin
            data(7, 1'b1);
            step(1'b1, 1'b1, 5'd5, 1'b1);
            chk("R5 lock on rapid marker", lock_a, 1);
        end

        phase = "R7";
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R7 lock after return to normal", lock_a, 1);
        for (int k = 0; k < 3; k++) begin
            data(NTC, 1'b0);
            step(1'b1, k == 1 ? 1'b0 : 1'b1, 5'd9, 1'b0);
            chk("R7 three misses keep lock", lock_a, 1);
        end

        phase = "R8";
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R8 match keeps lock", lock_a, 1);
        for (int k = 0; k < 3; k++) begin
            data(NTC, 1'b0);
            step(1'b1, 1'b1, 5'd2, 1'b0);
            chk("R8 misses after match keep lock", lock_a, 1);
        end
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b0);

        phase = "R9";
        for (int k = 0; k < 4; k++) begin
            data(NTC, 1'b0);
            step(1'b1, 1'b0, 5'd0, 1'b0);
            if (k < 3) chk("R9 lock before fourth miss", lock_a, 1);
        end
        chk("R9 lock dropped on fourth miss", lock_a, 0);
        chk("R9 slip on fourth miss", slip_a, 1);

        phase = "R10";
        repeat (5) step(1'b1, 1'b1, 5'd5, 1'b0);
        chk("R10 slip held", slip_a, 1);
        chk("R10 no lock while slipping", lock_a, 0);
        done_pulse();
        chk("R10 slip released", slip_a, 0);
        chk("R10 unlocked after slip", lock_a, 0);

        phase = "R3";
        step(1'b1, 1'b1, 5'd9, 1'b0);
        chk("R3 lane recaptured", lane_a, 9);
        data(NTC, 1'b0);
        step(1'b1, 1'b1, 5'd3, 1'b0);
        chk("R3 slip on wrong lane", slip_a, 1);
        chk("R3 no lock", lock_a, 0);
        done_pulse();

        phase = "R5";
        do_reset();
        chk("R1 reset clears lane", lane_a, 0);
        acquire5();
        chk("R5 100G locked", lock_a, 1);
        chk("R5 40G locked", lock_b, 1);
        data(3, 1'b0);
        step(1'b1, 1'b1, 5'd5, 1'b1);
        for (int k = 1; k <= 8; k++) begin
            data(7, 1'b1);
            step(1'b1, 1'b1, (k % 2 == 1) ? 5'd5 : 5'd7, 1'b1);
            if (k == 6) chk("R5 40G locked after three misses", lock_b, 1);
        end
        chk("R5 100G keeps lock", lock_a, 1);
        chk("R5 100G no slip", slip_a, 0);
        chk("R5 40G lost lock", lock_b, 0);
        chk("R5 40G slips", slip_b, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule